// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether an incoming frame is kept. It watches the first six bytes of the frame, which are the destination address, as they stream in one byte per transfer. It compares them with a programmed station address and detects the all-ones broadcast address. For any other group address it looks up one bit of a 64-bit hash table. A CRC-32 of the address bytes, built as they arrive, selects that bit. Promiscuous and monitor controls sit on top of these three address classes.

The byte stream uses valid/ready. The filter never applies back-pressure: `in_ready` is held high. A byte counts only when `in_valid` is high on a clock edge. `in_first` marks the first address byte of a frame and restarts the filter at any time. Once six address bytes have been taken, later bytes without `in_first` are consumed and have no effect. One cycle after the sixth byte, the block raises a single-cycle decision strobe together with accept, store, group and broadcast flags. The station address, hash table and mode pins are plain control inputs. They are sampled on the edge that takes the sixth byte.

Top module: `rx_dest_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dec_valid` is low and `in_ready` is high.
- R2: `dec_valid` pulses for exactly one cycle, in the cycle after the edge that takes the sixth address byte. Bytes taken after the sixth and before the next `in_first` produce no decision.
- R3: A frame whose first address bit is clear is accepted only when all six bytes equal `stn_addr`, and it is not accepted when any single bit differs. Byte k on the wire is `stn_addr[8k+7:8k]`, and the first byte is k=0.
- R4: The all-ones address sets `dec_bcast` and `dec_mcast`. It is accepted exactly when `cfg_bcast` is high, whatever the hash table holds.
- R5: A group address other than broadcast is accepted exactly when `cfg_mcast` is high and `hash_tbl[idx]` is 1. That bit is bit idx%8 of table byte idx/8. The CRC starts at all ones and uses the reflected polynomial 0xEDB88320. Each byte is taken LSB first, in wire order, and the final value is not inverted. idx is the CRC's low 6 bits in reversed order: CRC bit 0 becomes idx bit 5, and so on down to CRC bit 5, which becomes idx bit 0.
- R6: `dec_mcast` equals bit 0 of the first address byte.
- R7: With `cfg_prom` high every address is accepted.
- R8: `dec_store` equals `dec_accept` with `cfg_monitor` low and is 0 with `cfg_monitor` high. `cfg_monitor` does not change `dec_accept`.
- R9: Cycles with `in_valid` low inside the address leave the result unchanged. A byte with `in_first` before the sixth byte discards the partial address, so only the restarted address is judged.
- R10: `in_ready` stays high in every cycle after reset, including the decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte transfer valid |
| in_ready | output | 1 | Always high; the filter never stalls |
| in_first | input | 1 | Marks the first destination byte of a frame |
| in_data | input | 8 | Received byte |
| stn_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| hash_tbl | input | 64 | Group hash table, byte n in bits 8n+7:8n |
| cfg_bcast | input | 1 | Accept the broadcast address |
| cfg_mcast | input | 1 | Accept hashed group addresses |
| cfg_prom | input | 1 | Accept every address |
| cfg_monitor | input | 1 | Judge frames but request no storage |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Address passes the filter |
| dec_store | output | 1 | Accepted and not in monitor mode |
| dec_mcast | output | 1 | Group address |
| dec_bcast | output | 1 | Broadcast address |

## Verification
Two things can land in the same cycle: the decision strobe for one frame and the `in_first` byte of the next frame. The bench sends frames back to back to make this happen. In the cycle where the first frame's verdict appears, it drives the next frame's first byte. It then checks that verdict and afterwards the second frame's own verdict, each against its own address. The hash path is swept over 256 group addresses under several table patterns. The address classes are crossed with all sixteen mode combinations. Every expected result comes from a CRC computed in the bench.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  typedef struct packed {
    logic accept;
    logic store;
    logic mcast;
    logic bcast;
  } verdict_t;
endpackage

// File: rtl/rxf_byte_track.sv
module rxf_byte_track #(
  parameter int ADDR_BYTES = 6,
  localparam int POS_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  output logic             take,
  output logic [POS_W-1:0] pos,
  output logic             last
);
  logic [POS_W-1:0] cnt_q;

  always_comb begin
    pos  = in_first ? '0 : cnt_q;
    take = in_valid && (in_first || (cnt_q < POS_W'(ADDR_BYTES)));
    last = take && (pos == POS_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= POS_W'(ADDR_BYTES);
    else if (take) cnt_q <= pos + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= POS_W'(ADDR_BYTES)); // R2
endmodule

// File: rtl/rxf_crc_acc.sv
module rxf_crc_acc
  import rx_dest_filter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              restart,
  input  logic [DATA_W-1:0] data,
  output logic [31:0]       crc_next
);
  logic [31:0] crc_q;

  function automatic logic [31:0] crc_bytes(input logic [31:0] c_in,
                                            input logic [DATA_W-1:0] d);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < DATA_W; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

  assign crc_next = crc_bytes(restart ? CRC_SEED : crc_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_next;
  end
endmodule

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 6,
  localparam int POS_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take,
  input  logic [POS_W-1:0]             pos,
  input  logic [DATA_W-1:0]            data,
  input  logic [ADDR_BYTES*DATA_W-1:0] stn_addr,
  output logic                         match_n,
  output logic                         ones_n,
  output logic                         grp_n
);
  logic [DATA_W-1:0] stn_b [ADDR_BYTES];
  logic match_q, ones_q, grp_q;
  logic [DATA_W-1:0] ref_b;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_unpack
    assign stn_b[k] = stn_addr[k*DATA_W +: DATA_W];
  end

  always_comb begin
    ref_b = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (pos == POS_W'(k)) ref_b = stn_b[k];
  end

  always_comb begin
    if (pos == '0) begin
      match_n = (data == ref_b);
      ones_n  = &data;
      grp_n   = data[0];
    end else begin
      match_n = match_q && (data == ref_b);
      ones_n  = ones_q && (&data);
      grp_n   = grp_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      ones_q  <= 1'b0;
      grp_q   <= 1'b0;
    end else if (take) begin
      match_q <= match_n;
      ones_q  <= ones_n;
      grp_q   <= grp_n;
    end
  end

  AST_BCAST_IS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q |-> grp_q); // R4
endmodule

// File: rtl/rxf_hash_sel.sv
module rxf_hash_sel #(
  parameter int HASH_BITS = 6,
  localparam int TBL_BITS  = 1 << HASH_BITS,
  localparam int TBL_BYTES = TBL_BITS / 8
) (
  input  logic [31:0]         crc,
  input  logic [TBL_BITS-1:0] table_bits,
  output logic                hit
);
  logic [HASH_BITS-1:0] idx;
  logic [7:0]           tbl_b [TBL_BYTES];

  for (genvar i = 0; i < HASH_BITS; i++) begin : g_rev
    assign idx[i] = crc[HASH_BITS-1-i];
  end

  for (genvar n = 0; n < TBL_BYTES; n++) begin : g_bytes
    assign tbl_b[n] = table_bits[n*8 +: 8];
  end

  assign hit = tbl_b[idx[HASH_BITS-1:3]][idx[2:0]];
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_dest_filter_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int POS_W    = $clog2(ADDR_BYTES + 1),
  localparam int TBL_BITS = 1 << HASH_BITS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_first,
  input  logic [DATA_W-1:0]            in_data,
  input  logic [ADDR_BYTES*DATA_W-1:0] stn_addr,
  input  logic [TBL_BITS-1:0]          hash_tbl,
  input  logic                         cfg_bcast,
  input  logic                         cfg_mcast,
  input  logic                         cfg_prom,
  input  logic                         cfg_monitor,
  output logic                         dec_valid,
  output logic                         dec_accept,
  output logic                         dec_store,
  output logic                         dec_mcast,
  output logic                         dec_bcast
);
  logic             take, last;
  logic [POS_W-1:0] pos;
  logic [31:0]      crc_next;
  logic             match_n, ones_n, grp_n, hit;
  verdict_t         v_n, v_q;
  logic             valid_q;

  assign in_ready = 1'b1;

  rxf_byte_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .take(take), .pos(pos), .last(last));

  rxf_crc_acc #(.DATA_W(DATA_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .restart(pos == '0),
    .data(in_data), .crc_next(crc_next));

  rxf_addr_cmp #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES)) u_cmp (
    .clk(clk), .rst_n(rst_n), .take(take), .pos(pos), .data(in_data),
    .stn_addr(stn_addr), .match_n(match_n), .ones_n(ones_n), .grp_n(grp_n));

  rxf_hash_sel #(.HASH_BITS(HASH_BITS)) u_hash (
    .crc(crc_next), .table_bits(hash_tbl), .hit(hit));

  always_comb begin
    v_n.bcast = ones_n;
    v_n.mcast = grp_n;
    if (cfg_prom)    v_n.accept = 1'b1;
    else if (ones_n) v_n.accept = cfg_bcast;
    else if (grp_n)  v_n.accept = cfg_mcast && hit;
    else             v_n.accept = match_n;
    v_n.store = v_n.accept && !cfg_monitor;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      v_q     <= '0;
    end else begin
      valid_q <= last;
      if (last) v_q <= v_n;
    end
  end

  assign dec_valid  = valid_q;
  assign dec_accept = v_q.accept;
  assign dec_store  = v_q.store;
  assign dec_mcast  = v_q.mcast;
  assign dec_bcast  = v_q.bcast;

  AST_DEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R2
  AST_DEC_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid)); // R2
  AST_PROM_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(cfg_prom)) |-> dec_accept); // R7
  AST_STORE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_store) |-> dec_accept); // R8
  AST_BCAST_FLAGS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_bcast) |-> dec_mcast); // R4
endmodule

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic [7:0] in_data = '0;
  logic [47:0] stn_addr = 48'h6655_4433_2210;
  logic [63:0] hash_tbl = '0;
  logic cfg_bcast = 0, cfg_mcast = 0, cfg_prom = 0, cfg_monitor = 0;
  logic in_ready, dec_valid, dec_accept, dec_store, dec_mcast, dec_bcast;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_data(in_data), .stn_addr(stn_addr),
    .hash_tbl(hash_tbl), .cfg_bcast(cfg_bcast), .cfg_mcast(cfg_mcast),
    .cfg_prom(cfg_prom), .cfg_monitor(cfg_monitor), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_store(dec_store), .dec_mcast(dec_mcast),
    .dec_bcast(dec_bcast));

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [5:0] r;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ a[8*k + b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    for (int i = 0; i < 6; i++) r[5-i] = c[i];
    return r;
  endfunction

  // {valid, accept, store, mcast, bcast}
  function automatic logic [4:0] ref_dec(input logic [47:0] a);
    logic grp = a[0];
    logic bc  = (a == '1);
    logic acc;
    if (cfg_prom)  acc = 1'b1;
    else if (bc)   acc = cfg_bcast;
    else if (grp)  acc = cfg_mcast & hash_tbl[ref_idx(a)];
    else           acc = (a == stn_addr);
    return {1'b1, acc, acc & ~cfg_monitor, grp, bc};
  endfunction

  function automatic logic [4:0] got();
    return {dec_valid, dec_accept, dec_store, dec_mcast, dec_bcast};
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic f);
    @(negedge clk);
    in_valid = 1'b1; in_first = f; in_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  // drives six bytes and returns at the negedge where the verdict is visible
  task automatic send(input logic [47:0] a, input bit gap);
    for (int i = 0; i < 6; i++) begin
      if (gap && i == 3) idle();
      put(a[8*i +: 8], i == 0);
    end
    idle();
  endtask

  task automatic set_cfg(input logic [3:0] m);
    {cfg_prom, cfg_monitor, cfg_mcast, cfg_bcast} = m;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    logic [63:0] t;
    repeat (3) @(negedge clk);
    chk("R1", {dec_valid, 3'b000, in_ready}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {dec_valid, 3'b000, in_ready}, 5'b00001);

    // R3/R4/R6/R7/R8: address classes across all mode combinations
    hash_tbl = 64'hA5C3_0F96_5A3C_F069;
    for (int m = 0; m < 16; m++) begin
      set_cfg(m[3:0]);
      send(stn_addr, 0); chk("R3", got(), ref_dec(stn_addr));
      for (int bi = 0; bi < 48; bi++) begin
        a = stn_addr ^ (48'h1 << bi);
        send(a, 0);
        chk(bi == 0 ? "R6" : (m[3] ? "R7" : "R3"), got(), ref_dec(a));
      end
      send('1, 0); chk("R4", got(), ref_dec('1));
      for (int j = 0; j < 4; j++) begin
        a = {8'(j * 37), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
        send(a, 0); chk(m[2] ? "R8" : "R5", got(), ref_dec(a));
      end
    end

    // R5: hash sweep over group addresses and table patterns
    set_cfg(4'b0010);
    t = 64'h0123_4567_89AB_CDEF;
    for (int p = 0; p < 6; p++) begin
      hash_tbl = (p == 0) ? '0 : (p == 1) ? '1 : t;
      t = t * 64'd6364136223846793005 + 64'd1442695040888963407;
      for (int x = 0; x < 256; x++) begin
        a = {x[7:0], 8'h5A, 8'h00, 8'h5E, 8'h00, 8'h01};
        send(a, 0); chk("R5", got(), ref_dec(a));
      end
    end
    // broadcast ignores the table
    hash_tbl = '1; cfg_bcast = 0;
    send('1, 0); chk("R4", got(), ref_dec('1));

    // R2: trailing bytes produce no further decision
    set_cfg(4'b0001);
    send(stn_addr, 0); chk("R2", got(), ref_dec(stn_addr));
    begin
      bit seen = 0;
      for (int k = 0; k < 8; k++) begin
        put(8'hFF, 1'b0);
        if (k > 0 && dec_valid) seen = 1;
      end
      idle(); if (dec_valid) seen = 1;
      idle(); if (dec_valid) seen = 1;
      chk("R2", {4'b0, seen}, 5'b0);
    end

    // R9: gap inside the address and restart by in_first
    send(stn_addr, 1); chk("R9", got(), ref_dec(stn_addr));
    begin
      bit seen = 0;
      put(8'hFF, 1'b1);
      for (int k = 0; k < 4; k++) begin put(8'hFF, 1'b0); if (dec_valid) seen = 1; end
      for (int i = 0; i < 6; i++) begin
        put(stn_addr[8*i +: 8], i == 0);
        if (i < 6 && dec_valid) seen = 1;
      end
      idle();
      chk("R9", got(), ref_dec(stn_addr));
      chk("R9", {4'b0, seen}, 5'b0);
    end

    // R2/R10: back-to-back frames, verdict coincides with next first byte
    set_cfg(4'b0011);
    a = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h03};
    for (int i = 0; i < 6; i++) put(a[8*i +: 8], i == 0);
    put(stn_addr[7:0], 1'b1);
    chk("R2", got(), ref_dec(a));
    chk("R10", {4'b0, in_ready}, 5'b00001);
    for (int i = 1; i < 6; i++) begin
      put(stn_addr[8*i +: 8], 1'b0);
      chk("R2", {dec_valid, 4'b0}, 5'b0);
    end
    idle();
    chk("R2", got(), ref_dec(stn_addr));
    idle();
    chk("R2", {dec_valid, 4'b0}, 5'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule